// File: doc/BRIEF.md
# Windowed Bidirectional Row Scan Register

This block is the scan core of a row driver for a dot-matrix passive-matrix display. A chain of `STAGES` one-bit stages (240 by default) carries a scan token from one serial port to the other. The token moves one stage on every falling edge of the shift clock. A direction input chooses which serial port feeds the chain and which one taps it. A two-bit size selector reduces the active length to a window of stages centred in the chain. The serial entry and tap points then sit at the edges of that window.

Each stage turns its token bit into a two-bit drive-level code. The inputs to that code are the window, an active-low blanking input and a polarity signal. The polarity signal takes one rising edge and the following falling edge to reach the codes, so it changes together with the newly shifted data. Blanking silences every output at once but leaves the chain contents alone. The analog level shifting and the high-voltage output stages sit outside the block, which only presents the symbolic codes.

Top module: `scan_row_driver`

## Requirements
- R1: With `dir_fwd` = 1, every falling edge of `shift_clk` loads `ser_b_in` into the lowest-numbered stage of the window, and each other window stage takes the value of the stage numbered one below it. `ser_a_in` has no effect in this direction.
- R2: With `dir_fwd` = 0, every falling edge loads `ser_a_in` into the highest-numbered stage of the window, and each other window stage takes the value of the stage numbered one above it. `ser_b_in` has no effect in this direction.
- R3: With `dir_fwd` = 1, `ser_a_oe` = 1 and `ser_b_oe` = 0, `ser_a_out` shows the highest window stage and `ser_b_out` is 0. With `dir_fwd` = 0 the roles are mirrored: `ser_b_out` shows the lowest window stage with `ser_b_oe` = 1, and `ser_a_out` = 0 with `ser_a_oe` = 0.
- R4: Stage s (numbered 1 to STAGES) drives `drive_codes[2s-1:2s-2]`. The code 2'b00 means idle (non-select), 2'b01 means positive select and 2'b10 means negative select. A window stage holding 1 shows 2'b01 when the applied polarity is 0 and 2'b10 when it is 1. A stage holding 0 shows 2'b00. The code 2'b11 never appears.
- R5: While `blank_n` = 0, every code is 2'b00 without waiting for a clock edge. The chain keeps shifting and its contents are not cleared, so they reappear when `blank_n` returns to 1.
- R6: `win_sel` (bit 1 the first selector, bit 0 the second) picks the window: 2'b11 is stages 1–240, 2'b10 is stages 21–220, 2'b01 is stages 41–200 and 2'b00 is stages 61–180. Stages outside the window always show 2'b00, whatever they hold.
- R7: `pol_in` is sampled on a rising edge of `shift_clk` and reaches the codes on the falling edge that follows, so a change made after a rising edge shows only after the second falling edge.
- R8: `rst_n` = 0 asynchronously clears every stage and the polarity pipeline. All codes then read 2'b00 and both serial outputs read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| shift_clk | input | 1 | Shift clock. Data moves on its falling edge and polarity is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_fwd | input | 1 | 1: feed from port B and shift toward higher stages. 0: feed from port A and shift toward lower stages |
| win_sel | input | 2 | Window size selector |
| pol_in | input | 1 | Drive polarity |
| blank_n | input | 1 | Active-low blanking |
| ser_a_in | input | 1 | Serial input of port A, used when `dir_fwd` = 0 |
| ser_b_in | input | 1 | Serial input of port B, used when `dir_fwd` = 1 |
| ser_a_out | output | 1 | Serial output of port A: the highest window stage when `dir_fwd` = 1 |
| ser_a_oe | output | 1 | Port A drives out |
| ser_b_out | output | 1 | Serial output of port B: the lowest window stage when `dir_fwd` = 0 |
| ser_b_oe | output | 1 | Port B drives out |
| drive_codes | output | 2*STAGES | Packed drive-level codes, stage 1 in bits 1:0 |

## Verification
A single token is walked through the full window in the forward direction and through the narrowest window in reverse. This shows whether the entry stage, the step direction and the exit tap follow `dir_fwd` and `win_sel`, and whether the unused serial input really has no effect. A four-bit pattern with a gap tells apart a chain that keeps its bit order from one that smears or drops bits. The entry stages of the two middle windows confirm how the selector is decoded. Further runs toggle polarity right after a rising edge, blank during shifting, and switch the window while the token sits outside it. Together these separate the one-edge polarity delay, blanking that gates without clearing, and window gating that hides the contents rather than losing them.

// File: rtl/scan_drv_pkg.sv
package scan_drv_pkg;

    // Symbolic drive levels presented per stage
    typedef enum logic [1:0] {
        LVL_IDLE = 2'b00,
        LVL_POS  = 2'b01,
        LVL_NEG  = 2'b10
    } drive_lvl_e;

    // Window size selector values; the trim from each chain end grows as the value falls
    typedef enum logic [1:0] {
        WIN_NARROW = 2'b00,
        WIN_MID    = 2'b01,
        WIN_WIDE   = 2'b10,
        WIN_FULL   = 2'b11
    } win_size_e;

endpackage

// File: rtl/scan_window_dec.sv
module scan_window_dec #(
    parameter int STAGES    = 240,
    parameter int TRIM_STEP = 20,
    parameter int IDX_W     = $clog2(STAGES)
) (
    input  logic [1:0]        win_sel,
    output logic [IDX_W-1:0]  first_idx,
    output logic [IDX_W-1:0]  last_idx,
    output logic [STAGES-1:0] in_win
);
    import scan_drv_pkg::*;

    localparam logic [IDX_W-1:0] STEP_1 = IDX_W'(TRIM_STEP);
    localparam logic [IDX_W-1:0] STEP_2 = IDX_W'(2 * TRIM_STEP);
    localparam logic [IDX_W-1:0] STEP_3 = IDX_W'(3 * TRIM_STEP);
    localparam logic [IDX_W-1:0] TOP    = IDX_W'(STAGES - 1);

    logic [IDX_W-1:0] trim;

    always_comb begin
        unique case (win_size_e'(win_sel))
            WIN_FULL:   trim = '0;
            WIN_WIDE:   trim = STEP_1;
            WIN_MID:    trim = STEP_2;
            WIN_NARROW: trim = STEP_3;
        endcase
    end

    assign first_idx = trim;
    assign last_idx  = TOP - trim;

    for (genvar i = 0; i < STAGES; i++) begin : g_mask
        assign in_win[i] = (IDX_W'(i) >= first_idx) && (IDX_W'(i) <= last_idx);
    end

endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
    parameter int STAGES = 240,
    parameter int IDX_W  = $clog2(STAGES)
) (
    input  logic              shift_clk,
    input  logic              rst_n,
    input  logic              dir_fwd,
    input  logic [IDX_W-1:0]  first_idx,
    input  logic [IDX_W-1:0]  last_idx,
    input  logic              ser_a_in,
    input  logic              ser_b_in,
    output logic [STAGES-1:0] stage_q
);
    logic [STAGES-1:0] stage_nxt;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic from_below;
        logic from_above;

        if (i == 0) begin : g_bottom
            assign from_below = 1'b0;
        end else begin : g_below
            assign from_below = stage_q[i-1];
        end

        if (i == STAGES - 1) begin : g_top
            assign from_above = 1'b0;
        end else begin : g_above
            assign from_above = stage_q[i+1];
        end

        always_comb begin
            if (dir_fwd) begin
                stage_nxt[i] = (first_idx == IDX_W'(i)) ? ser_b_in : from_below;
            end else begin
                stage_nxt[i] = (last_idx == IDX_W'(i)) ? ser_a_in : from_above;
            end
        end
    end

    always_ff @(negedge shift_clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_nxt;
        end
    end

endmodule

// File: rtl/pol_pipe.sv
module pol_pipe (
    input  logic shift_clk,
    input  logic rst_n,
    input  logic pol_in,
    output logic pol_act
);
    logic pol_smp;

    always_ff @(posedge shift_clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_smp <= 1'b0;
        end else begin
            pol_smp <= pol_in;
        end
    end

    always_ff @(negedge shift_clk or negedge rst_n) begin
        if (!rst_n) begin
            pol_act <= 1'b0;
        end else begin
            pol_act <= pol_smp;
        end
    end

endmodule

// File: rtl/level_enc.sv
module level_enc #(
    parameter int STAGES = 240
) (
    input  logic [STAGES-1:0]   stage_q,
    input  logic [STAGES-1:0]   in_win,
    input  logic                pol_act,
    input  logic                blank_n,
    output logic [2*STAGES-1:0] drive_codes
);
    import scan_drv_pkg::*;

    for (genvar i = 0; i < STAGES; i++) begin : g_enc
        drive_lvl_e lvl;

        always_comb begin
            if (!blank_n || !in_win[i] || !stage_q[i]) begin
                lvl = LVL_IDLE;
            end else if (pol_act) begin
                lvl = LVL_NEG;
            end else begin
                lvl = LVL_POS;
            end
        end

        assign drive_codes[2*i +: 2] = lvl;
    end

endmodule

// File: rtl/scan_row_driver.sv
module scan_row_driver #(
    parameter int STAGES    = 240,
    parameter int TRIM_STEP = 20
) (
    input  logic                shift_clk,
    input  logic                rst_n,
    input  logic                dir_fwd,
    input  logic [1:0]          win_sel,
    input  logic                pol_in,
    input  logic                blank_n,
    input  logic                ser_a_in,
    input  logic                ser_b_in,
    output logic                ser_a_out,
    output logic                ser_a_oe,
    output logic                ser_b_out,
    output logic                ser_b_oe,
    output logic [2*STAGES-1:0] drive_codes
);
    localparam int IDX_W = $clog2(STAGES);

    logic [IDX_W-1:0]  first_idx;
    logic [IDX_W-1:0]  last_idx;
    logic [STAGES-1:0] in_win;
    logic [STAGES-1:0] stage_q;
    logic              pol_act;

    scan_window_dec #(
        .STAGES    (STAGES),
        .TRIM_STEP (TRIM_STEP),
        .IDX_W     (IDX_W)
    ) u_win (
        .win_sel   (win_sel),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .in_win    (in_win)
    );

    scan_chain #(
        .STAGES (STAGES),
        .IDX_W  (IDX_W)
    ) u_chain (
        .shift_clk (shift_clk),
        .rst_n     (rst_n),
        .dir_fwd   (dir_fwd),
        .first_idx (first_idx),
        .last_idx  (last_idx),
        .ser_a_in  (ser_a_in),
        .ser_b_in  (ser_b_in),
        .stage_q   (stage_q)
    );

    pol_pipe u_pol (
        .shift_clk (shift_clk),
        .rst_n     (rst_n),
        .pol_in    (pol_in),
        .pol_act   (pol_act)
    );

    level_enc #(
        .STAGES (STAGES)
    ) u_enc (
        .stage_q     (stage_q),
        .in_win      (in_win),
        .pol_act     (pol_act),
        .blank_n     (blank_n),
        .drive_codes (drive_codes)
    );

    // Serial taps sit at the far window edge for the chosen direction
    assign ser_a_oe  = dir_fwd;
    assign ser_b_oe  = ~dir_fwd;
    assign ser_a_out = dir_fwd & stage_q[last_idx];
    assign ser_b_out = ~dir_fwd & stage_q[first_idx];

endmodule

// File: rtl/scan_row_driver_chk.sv
module scan_row_driver_chk #(
    parameter int STAGES    = 240,
    parameter int TRIM_STEP = 20
) (
    input logic                shift_clk,
    input logic                rst_n,
    input logic                dir_fwd,
    input logic [1:0]          win_sel,
    input logic                blank_n,
    input logic                ser_a_out,
    input logic                ser_b_out,
    input logic [2*STAGES-1:0] drive_codes
);
    int         margin;
    logic       reserved_seen;
    logic       outside_hot;
    logic [1:0] top_code;
    logic [1:0] bottom_code;

    always_comb begin
        margin        = (3 - int'(win_sel)) * TRIM_STEP;
        reserved_seen = 1'b0;
        outside_hot   = 1'b0;
        for (int s = 0; s < STAGES; s++) begin
            if (drive_codes[2*s +: 2] == 2'b11) reserved_seen = 1'b1;
            if ((s < margin || s > STAGES - 1 - margin) && drive_codes[2*s +: 2] != 2'b00)
                outside_hot = 1'b1;
        end
        top_code    = drive_codes[2*(STAGES - 1 - margin) +: 2];
        bottom_code = drive_codes[2*margin +: 2];
    end

    a_r5_blank_idle: assert property (@(posedge shift_clk) disable iff (!rst_n)
        !blank_n |-> drive_codes == '0);

    a_r6_outside_idle: assert property (@(posedge shift_clk) disable iff (!rst_n)
        !outside_hot);

    a_r4_no_reserved_code: assert property (@(posedge shift_clk) disable iff (!rst_n)
        !reserved_seen);

    a_r3_fwd_tap: assert property (@(posedge shift_clk) disable iff (!rst_n)
        (blank_n && dir_fwd) |-> (ser_a_out == (top_code != 2'b00)) && !ser_b_out);

    a_r3_rev_tap: assert property (@(posedge shift_clk) disable iff (!rst_n)
        (blank_n && !dir_fwd) |-> (ser_b_out == (bottom_code != 2'b00)) && !ser_a_out);

endmodule

bind scan_row_driver scan_row_driver_chk #(
    .STAGES    (STAGES),
    .TRIM_STEP (TRIM_STEP)
) u_chk (
    .shift_clk   (shift_clk),
    .rst_n       (rst_n),
    .dir_fwd     (dir_fwd),
    .win_sel     (win_sel),
    .blank_n     (blank_n),
    .ser_a_out   (ser_a_out),
    .ser_b_out   (ser_b_out),
    .drive_codes (drive_codes)
);

// File: tb/scan_row_driver_test.sv
module scan_row_driver_test;
    localparam int CLK_PERIOD = 20;
    localparam int N          = 240;

    logic           shift_clk = 1'b0;
    logic           rst_n     = 1'b0;
    logic           dir_fwd   = 1'b1;
    logic [1:0]     win_sel   = 2'b11;
    logic           pol_in    = 1'b0;
    logic           blank_n   = 1'b1;
    logic           ser_a_in  = 1'b0;
    logic           ser_b_in  = 1'b0;
    logic           ser_a_out;
    logic           ser_a_oe;
    logic           ser_b_out;
    logic           ser_b_oe;
    logic [2*N-1:0] drive_codes;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #(CLK_PERIOD/2) shift_clk = ~shift_clk;

    scan_row_driver uut (
        .shift_clk   (shift_clk),
        .rst_n       (rst_n),
        .dir_fwd     (dir_fwd),
        .win_sel     (win_sel),
        .pol_in      (pol_in),
        .blank_n     (blank_n),
        .ser_a_in    (ser_a_in),
        .ser_b_in    (ser_b_in),
        .ser_a_out   (ser_a_out),
        .ser_a_oe    (ser_a_oe),
        .ser_b_out   (ser_b_out),
        .ser_b_oe    (ser_b_oe),
        .drive_codes (drive_codes)
    );

    function automatic logic [2*N-1:0] one_code(input int stage, input logic [1:0] code);
        logic [2*N-1:0] v = '0;
        v[2*(stage-1) +: 2] = code;
        return v;
    endfunction

    task automatic check_codes(input string tag, input logic [2*N-1:0] exp);
        checks++;
        if (drive_codes !== exp) begin
            fails++;
            $display("FAIL %s: drive_codes=%h expected %h", tag, drive_codes, exp);
        end
    endtask

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    // Advance through n falling edges; return 2 ns after the last one
    task automatic shift_n(input int n);
        repeat (n) begin
            @(negedge shift_clk);
            #2;
        end
    endtask

    // Called in the low phase; clears asynchronously and checks the cleared state
    task automatic do_reset();
        rst_n = 1'b0;
        #1;
        check_codes("R8 async clear", '0);
        check_bit("R8 ser_a_out cleared", ser_a_out, 1'b0);
        check_bit("R8 ser_b_out cleared", ser_b_out, 1'b0);
        #1;
        rst_n = 1'b1;
    endtask

    task automatic t_fwd_full();
        do_reset();
        dir_fwd = 1'b1; win_sel = 2'b11; pol_in = 1'b0; blank_n = 1'b1;
        ser_a_in = 1'b1; ser_b_in = 1'b1;
        shift_n(1);
        ser_b_in = 1'b0;
        check_codes("R1 token at stage 1", one_code(1, 2'b01));
        shift_n(1);
        check_codes("R1 token at stage 2", one_code(2, 2'b01));
        shift_n(237);
        check_codes("R1 token at stage 239", one_code(239, 2'b01));
        check_bit("R3 fwd tap before end", ser_a_out, 1'b0);
        shift_n(1);
        check_codes("R1 token at stage 240", one_code(240, 2'b01));
        check_bit("R3 fwd tap at end", ser_a_out, 1'b1);
        check_bit("R3 port A drives", ser_a_oe, 1'b1);
        check_bit("R3 port B listens", ser_b_oe, 1'b0);
        check_bit("R3 port B out quiet", ser_b_out, 1'b0);
        shift_n(1);
        check_codes("R1 token gone, port A input ignored", '0);
        ser_a_in = 1'b0;
    endtask

    task automatic t_fwd_pattern();
        do_reset();
        dir_fwd = 1'b1; win_sel = 2'b01; pol_in = 1'b0; blank_n = 1'b1;
        ser_b_in = 1'b1; shift_n(1);
        ser_b_in = 1'b1; shift_n(1);
        ser_b_in = 1'b0; shift_n(1);
        ser_b_in = 1'b1; shift_n(1);
        ser_b_in = 1'b0;
        check_codes("R1 pattern order in 41..200 window",
                    one_code(44, 2'b01) | one_code(43, 2'b01) | one_code(41, 2'b01));
    endtask

    task automatic t_rev_narrow();
        do_reset();
        dir_fwd = 1'b0; win_sel = 2'b00; pol_in = 1'b0; blank_n = 1'b1;
        ser_a_in = 1'b1; ser_b_in = 1'b1;
        shift_n(1);
        ser_a_in = 1'b0;
        check_codes("R2 token at stage 180", one_code(180, 2'b01));
        check_bit("R3 rev tap not yet", ser_b_out, 1'b0);
        shift_n(119);
        check_codes("R2 token at stage 61", one_code(61, 2'b01));
        check_bit("R3 rev tap at end", ser_b_out, 1'b1);
        check_bit("R3 port B drives", ser_b_oe, 1'b1);
        check_bit("R3 port A listens", ser_a_oe, 1'b0);
        check_bit("R3 port A out quiet", ser_a_out, 1'b0);
        shift_n(1);
        check_codes("R2 token gone, port B input ignored", '0);
        ser_b_in = 1'b0;
    endtask

    task automatic t_entries();
        do_reset();
        dir_fwd = 1'b1; win_sel = 2'b10; pol_in = 1'b0; blank_n = 1'b1;
        ser_b_in = 1'b1; shift_n(1); ser_b_in = 1'b0;
        check_codes("R6 window 21..220 forward entry", one_code(21, 2'b01));
        do_reset();
        dir_fwd = 1'b0; win_sel = 2'b01;
        ser_a_in = 1'b1; shift_n(1); ser_a_in = 1'b0;
        check_codes("R6 window 41..200 reverse entry", one_code(200, 2'b01));
    endtask

    task automatic t_pol();
        do_reset();
        dir_fwd = 1'b1; win_sel = 2'b11; pol_in = 1'b0; blank_n = 1'b1;
        ser_b_in = 1'b1; shift_n(1); ser_b_in = 1'b0;
        @(posedge shift_clk);
        #1;
        pol_in = 1'b1;
        shift_n(1);
        check_codes("R7 polarity not yet applied", one_code(2, 2'b01));
        shift_n(1);
        check_codes("R4 R7 negative select after second fall", one_code(3, 2'b10));
        pol_in = 1'b0;
        shift_n(1);
        check_codes("R4 positive select restored", one_code(4, 2'b01));
    endtask

    task automatic t_blank();
        do_reset();
        dir_fwd = 1'b1; win_sel = 2'b11; pol_in = 1'b0; blank_n = 1'b1;
        ser_b_in = 1'b1; shift_n(1); ser_b_in = 1'b0;
        blank_n = 1'b0;
        #1;
        check_codes("R5 blanking is immediate", '0);
        shift_n(3);
        check_codes("R5 blanked while shifting", '0);
        blank_n = 1'b1;
        #1;
        check_codes("R5 contents kept and shifted", one_code(4, 2'b01));
    endtask

    task automatic t_outside();
        do_reset();
        dir_fwd = 1'b1; win_sel = 2'b11; pol_in = 1'b0; blank_n = 1'b1;
        ser_b_in = 1'b1; shift_n(1); ser_b_in = 1'b0;
        shift_n(9);
        check_codes("R6 token at stage 10 full window", one_code(10, 2'b01));
        win_sel = 2'b00;
        #1;
        check_codes("R6 stage 10 hidden outside 61..180", '0);
        shift_n(1);
        check_codes("R6 still hidden after shift", '0);
        win_sel = 2'b11;
        #1;
        check_codes("R6 hidden contents reappear at stage 11", one_code(11, 2'b01));
    endtask

    initial begin
        #5;
        check_codes("R8 codes idle in reset", '0);
        check_bit("R8 ser_a_out idle in reset", ser_a_out, 1'b0);
        @(negedge shift_clk);
        #2;
        rst_n = 1'b1;
        t_fwd_full();
        t_fwd_pattern();
        t_rev_narrow();
        t_entries();
        t_pol();
        t_blank();
        t_outside();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule